// File: doc/BRIEF.md
# Dual 16-bit Match Timer

The block holds two independent 16-bit counters behind a small word-addressed register port. Each counter has three registers: a load value, a clock divider and a control word. The control word can start or stop the counter and sets whether it counts up or down. It also picks the condition at which the counter halts: reaching zero, equalling one of six shared compare registers, or never halting, so that it wraps.

When a counter that is enabled equals a compare register, the matching bit of a six-bit pending register is set. Software clears pending bits by writing ones to them. A mask register chooses which pending bits drive the single interrupt line. A typical use is to run one counter as a one-shot event timer that counts down to a compare value of zero, and to run the other as a free-running time base.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, every counter value, divider, compare register, the mask and the pending bits read 0, and both control words read 0x10 (stopped, decrementing, halt at zero).
- R2: With `winSel`=0, counter n (n=0,1) occupies byte offsets 0x0C*n + {0x00 value, 0x04 divider, 0x08 control}, and compare register x (x=0..5) sits at 0x18 + 4*x. With `winSel`=1, offset 0x00 reads pending and writes acknowledge, and 0x04 is the mask. Unmapped offsets read 0. `rdData` is combinational while `rdEn` is high and 0 otherwise.
- R3: Control bit 4 = 1 stops the counter, and a stopped counter holds its value. Bit 3 = 1 counts up and 0 counts down. The control word is 5 bits, and the upper read bits are 0.
- R4: Control bits 2:0 give the halt condition: 0 halts at a count of zero, x+1 halts when the count equals compare register x, and 7 never halts. A halted counter holds its value, and its control word is left unchanged.
- R5: A divider of 0 advances the counter on every clock. A divider N>0 advances it once every N+1 clocks. The prescale phase restarts whenever the divider or the value register is written.
- R6: A write to the value register loads the counter in the next cycle and takes priority over any step in that cycle. Counting wraps modulo 2^16.
- R7: Pending bit x is set the clock after any counter whose control bit 4 is 0 equals compare register x. A new hit wins over an acknowledge in the same cycle.
- R8: Writing 1 to a pending bit clears it, and bits written as 0 keep their value.
- R9: `irq` is high exactly when some pending bit is set and its mask bit is 1.
- R10: A counter changes by at most one step per clock unless its value register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| winSel | input | 1 | 0 = counter/compare window, 1 = interrupt window |
| addr | input | 6 | Byte offset inside the window |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench covers a counter that is already sitting on its halt target, and an acknowledge that lands while the compare stays true, where the pending bit must come straight back. A design that evaluated the halt after stepping would overshoot by one. Divider writes in the middle of a prescale period must restart the phase, or event times drift by up to N clocks. Free-running wraps must move through 0xFFFF to 0. Any stale match or wrong mask gating shows up as a mismatch on `irq`, which the bench compares against its model on every clock.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int NUM_CNT   = 2;
  localparam int NUM_MATCH = 6;
  localparam int CTL_W     = 5;
  localparam int STOP_BIT  = 4;
  localparam int UP_BIT    = 3;
  localparam logic [2:0] MODE_ZERO    = 3'd0;
  localparam logic [2:0] MODE_FOREVER = 3'd7;

  typedef enum logic [2:0] {
    RK_NONE, RK_VAL, RK_DIV, RK_CTL, RK_MATCH, RK_STAT, RK_MASK
  } rdKind_e;

  typedef struct packed {
    logic [NUM_CNT-1:0]   valWr;
    logic [NUM_CNT-1:0]   divWr;
    logic [NUM_CNT-1:0]   ctlWr;
    logic [NUM_MATCH-1:0] matchWr;
    logic                 ackWr;
    logic                 maskWr;
  } strobe_t;

  typedef struct packed {
    rdKind_e    kind;
    logic [2:0] idx;
  } rdReq_t;
endpackage

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              winSel,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output rdReq_t            rd
);
  localparam int WORD_W       = ADDR_W - 2;
  localparam int REGS_PER_CNT = 3;
  localparam int CNT_WORDS    = NUM_CNT * REGS_PER_CNT;
  localparam int MATCH_END    = CNT_WORDS + NUM_MATCH;

  logic [WORD_W-1:0] word;
  rdKind_e           kind;
  logic [2:0]        idx;

  assign word = addr[ADDR_W-1:2];

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (winSel) begin
      if (word == '0)                kind = RK_STAT;
      else if (word == WORD_W'(1))   kind = RK_MASK;
    end else if (int'(word) < CNT_WORDS) begin
      idx = 3'(int'(word) / REGS_PER_CNT);
      case (int'(word) % REGS_PER_CNT)
        0:       kind = RK_VAL;
        1:       kind = RK_DIV;
        default: kind = RK_CTL;
      endcase
    end else if (int'(word) < MATCH_END) begin
      kind = RK_MATCH;
      idx  = 3'(int'(word) - CNT_WORDS);
    end
  end

  always_comb begin
    stb = '0;
    for (int c = 0; c < NUM_CNT; c++) begin
      stb.valWr[c] = wrEn && kind == RK_VAL && idx == 3'(c);
      stb.divWr[c] = wrEn && kind == RK_DIV && idx == 3'(c);
      stb.ctlWr[c] = wrEn && kind == RK_CTL && idx == 3'(c);
    end
    for (int x = 0; x < NUM_MATCH; x++)
      stb.matchWr[x] = wrEn && kind == RK_MATCH && idx == 3'(x);
    stb.ackWr  = wrEn && kind == RK_STAT;
    stb.maskWr = wrEn && kind == RK_MASK;
  end

  assign rd.kind = rdEn ? kind : RK_NONE;
  assign rd.idx  = idx;
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            valWr,
  input  logic                            divWr,
  input  logic                            ctlWr,
  input  logic [CNT_W-1:0]                wrData,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVals,
  output logic [CNT_W-1:0]                count,
  output logic [CNT_W-1:0]                divisor,
  output logic [CTL_W-1:0]                ctl
);
  logic [CNT_W-1:0] prescale;
  logic [2:0]       mode;
  logic             endHit;
  logic             advance;
  logic             tick;

  assign mode = ctl[2:0];

  always_comb begin
    endHit = 1'b0;
    if (mode == MODE_ZERO) endHit = (count == '0);
    for (int i = 0; i < NUM_MATCH; i++)
      if (mode == 3'(i + 1)) endHit = (count == matchVals[i]);
  end

  assign advance = !ctl[STOP_BIT] && !endHit;
  assign tick    = advance && (prescale == divisor);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      divisor  <= '0;
      prescale <= '0;
      ctl      <= CTL_W'(1 << STOP_BIT);
    end else begin
      if (valWr)     count <= wrData;
      else if (tick) count <= ctl[UP_BIT] ? count + 1'b1 : count - 1'b1;

      if (valWr || divWr) prescale <= '0;
      else if (advance)   prescale <= tick ? '0 : prescale + 1'b1;

      if (divWr) divisor <= wrData;
      if (ctlWr) ctl     <= wrData[CTL_W-1:0];
    end
  end
endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         stb,
  input  rdReq_t                          rd,
  input  logic [CNT_W-1:0]                wrData,
  output logic [CNT_W-1:0]                rdData,
  output logic                            irq,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cntVal,
  output logic [NUM_CNT-1:0][CTL_W-1:0]   cntCtl,
  output logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal,
  output logic [NUM_MATCH-1:0]            intStatus,
  output logic [NUM_MATCH-1:0]            intMask
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cntDiv;
  logic [NUM_MATCH-1:0]          hits;

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    dmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .valWr    (stb.valWr[c]),
      .divWr    (stb.divWr[c]),
      .ctlWr    (stb.ctlWr[c]),
      .wrData   (wrData),
      .matchVals(matchVal),
      .count    (cntVal[c]),
      .divisor  (cntDiv[c]),
      .ctl      (cntCtl[c])
    );
  end

  for (genvar x = 0; x < NUM_MATCH; x++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rstN)              matchVal[x] <= '0;
      else if (stb.matchWr[x]) matchVal[x] <= wrData;
    end
  end

  always_comb begin
    hits = '0;
    for (int x = 0; x < NUM_MATCH; x++)
      for (int c = 0; c < NUM_CNT; c++)
        if (!cntCtl[c][STOP_BIT] && cntVal[c] == matchVal[x]) hits[x] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatus <= '0;
      intMask   <= '0;
    end else begin
      intStatus <= (intStatus & ~(stb.ackWr ? wrData[NUM_MATCH-1:0] : '0)) | hits;
      if (stb.maskWr) intMask <= wrData[NUM_MATCH-1:0];
    end
  end

  assign irq = |(intStatus & intMask);

  always_comb begin
    rdData = '0;
    case (rd.kind)
      RK_VAL, RK_DIV, RK_CTL:
        for (int c = 0; c < NUM_CNT; c++)
          if (rd.idx == 3'(c))
            rdData = (rd.kind == RK_VAL) ? cntVal[c] :
                     (rd.kind == RK_DIV) ? cntDiv[c] : CNT_W'(cntCtl[c]);
      RK_MATCH:
        for (int x = 0; x < NUM_MATCH; x++)
          if (rd.idx == 3'(x)) rdData = matchVal[x];
      RK_STAT: rdData = CNT_W'(intStatus);
      RK_MASK: rdData = CNT_W'(intMask);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              winSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  strobe_t                         stb;
  rdReq_t                          rd;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cntVal;
  logic [NUM_CNT-1:0][CTL_W-1:0]   cntCtl;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal;
  logic [NUM_MATCH-1:0]            intStatus;
  logic [NUM_MATCH-1:0]            intMask;

  dmt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .winSel(winSel),
    .addr  (addr),
    .stb   (stb),
    .rd    (rd)
  );

  dmt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rd       (rd),
    .wrData   (wrData),
    .rdData   (rdData),
    .irq      (irq),
    .cntVal   (cntVal),
    .cntCtl   (cntCtl),
    .matchVal (matchVal),
    .intStatus(intStatus),
    .intMask  (intMask)
  );
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic [CNT_W-1:0]                wrData,
  input strobe_t                         stb,
  input logic [NUM_CNT-1:0][CNT_W-1:0]   cntVal,
  input logic [NUM_CNT-1:0][CTL_W-1:0]   cntCtl,
  input logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal,
  input logic [NUM_MATCH-1:0]            intStatus,
  input logic [NUM_MATCH-1:0]            intMask,
  input logic                            irq
);
  for (genvar c = 0; c < NUM_CNT; c++) begin : g_c
    logic atEnd;
    always_comb begin
      atEnd = 1'b0;
      if (cntCtl[c][2:0] == MODE_ZERO) atEnd = (cntVal[c] == '0);
      for (int i = 0; i < NUM_MATCH; i++)
        if (cntCtl[c][2:0] == 3'(i + 1)) atEnd = (cntVal[c] == matchVal[i]);
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (cntCtl[c][STOP_BIT] && !stb.valWr[c]) |=> $stable(cntVal[c])); // R3

    AST_END_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!cntCtl[c][STOP_BIT] && atEnd && !stb.valWr[c]) |=> $stable(cntVal[c])); // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
      !stb.valWr[c] |=> ($stable(cntVal[c]) ||
                         cntVal[c] == CNT_W'($past(cntVal[c]) + 1'b1) ||
                         cntVal[c] == CNT_W'($past(cntVal[c]) - 1'b1))); // R10
  end

  for (genvar x = 0; x < NUM_MATCH; x++) begin : g_x
    AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
      $fell(intStatus[x]) |-> $past(stb.ackWr && wrData[x])); // R8
  end

  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && stb.maskWr && wrData[NUM_MATCH-1:0] == '0) |=> !irq); // R9
endmodule

bind dual_match_timer dmt_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_match_timer_test.sv
module dual_match_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, winSel = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;

  int nChk = 0, nFail = 0;
  bit running = 0;

  dual_match_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .winSel(winSel),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [15:0] mCnt[2], mDiv[2], mPre[2], mMatch[6], nCnt[2], nPre[2];
  logic [4:0]  mCtl[2];
  logic [5:0]  mStat, mMask, hit;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mCnt[c] = 0; mDiv[c] = 0; mPre[c] = 0; mCtl[c] = 5'h10;
      end
      for (int x = 0; x < 6; x++) mMatch[x] = 0;
      mStat = 0; mMask = 0;
    end else begin
      hit = 0;
      for (int x = 0; x < 6; x++)
        for (int c = 0; c < 2; c++)
          if (!mCtl[c][4] && mCnt[c] == mMatch[x]) hit[x] = 1;
      for (int c = 0; c < 2; c++) begin
        bit done;
        int md;
        md = int'(mCtl[c][2:0]);
        if (md == 0) done = (mCnt[c] == 0);
        else if (md == 7) done = 0;
        else done = (mCnt[c] == mMatch[md-1]);
        nCnt[c] = mCnt[c]; nPre[c] = mPre[c];
        if (!mCtl[c][4] && !done) begin
          if (mPre[c] == mDiv[c]) begin
            nPre[c] = 0;
            nCnt[c] = mCtl[c][3] ? mCnt[c] + 16'd1 : mCnt[c] - 16'd1;
          end else nPre[c] = mPre[c] + 16'd1;
        end
      end
      if (wrEn) begin
        int a;
        a = int'(addr);
        if (!winSel) begin
          if (a < 24) begin
            int c, r;
            c = a / 12; r = (a % 12) / 4;
            if (r == 0) begin nCnt[c] = wrData; nPre[c] = 0; end
            else if (r == 1) begin mDiv[c] = wrData; nPre[c] = 0; end
            else mCtl[c] = wrData[4:0];
          end else if (a < 48) mMatch[(a-24)/4] = wrData;
        end else begin
          if (a == 0) mStat = mStat & ~wrData[5:0];
          else if (a == 4) mMask = wrData[5:0];
        end
      end
      mStat = mStat | hit;
      for (int c = 0; c < 2; c++) begin mCnt[c] = nCnt[c]; mPre[c] = nPre[c]; end
    end
  end

  function automatic logic [15:0] mRead(bit w, int a);
    if (!w) begin
      if (a < 24) begin
        int c, r;
        c = a / 12; r = (a % 12) / 4;
        return (r == 0) ? mCnt[c] : (r == 1) ? mDiv[c] : {11'd0, mCtl[c]};
      end
      if (a < 48) return mMatch[(a-24)/4];
      return 0;
    end
    if (a == 0) return {10'd0, mStat};
    if (a == 4) return {10'd0, mMask};
    return 0;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // irq against the model on every clock (R9, R7)
  always @(negedge clk)
    if (running && rstN)
      check(irq == |(mStat & mMask), "R9 irq", {15'd0, irq}, {15'd0, |(mStat & mMask)});

  task automatic wr(bit w, int a, logic [15:0] d);
    @(negedge clk);
    winSel = w; addr = 6'(a); wrData = d; wrEn = 1; rdEn = 0;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic rdChk(bit w, int a, string tag);
    logic [15:0] e;
    @(negedge clk);
    winSel = w; addr = 6'(a); rdEn = 1; wrEn = 0;
    #1 e = mRead(w, a);
    check(rdData === e, tag, rdData, e);
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic rdLit(bit w, int a, logic [15:0] e, string tag);
    @(negedge clk);
    winSel = w; addr = 6'(a); rdEn = 1; wrEn = 0;
    #1 check(rdData === e, tag, rdData, e);
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rstN = 1;
    running = 1;
    // R1 reset state
    rdLit(0, 8'h08, 16'h0010, "R1 ctl0 reset");
    rdLit(0, 8'h14, 16'h0010, "R1 ctl1 reset");
    rdLit(0, 8'h00, 16'h0000, "R1 val0 reset");
    rdLit(0, 8'h2C, 16'h0000, "R1 match5 reset");
    rdLit(1, 8'h04, 16'h0000, "R1 mask reset");
    rdLit(1, 8'h00, 16'h0000, "R1 status reset");
    // R2 address map and unmapped reads
    wr(0, 8'h1C, 16'h1234);
    rdLit(0, 8'h1C, 16'h1234, "R2 match1 offset");
    rdLit(0, 8'h30, 16'h0000, "R2 unmapped timer window");
    rdLit(1, 8'h08, 16'h0000, "R2 unmapped interrupt window");
    @(negedge clk); rdEn = 0; winSel = 0; addr = 6'h1C;
    #1 check(rdData == 0, "R2 rdData zero without rdEn", rdData, 0);
    wr(0, 8'h1C, 16'h0000);
    // one-shot down count to compare 0 (R4, R7, R9)
    wr(1, 8'h04, 16'h003F);
    wr(0, 8'h00, 16'd5);
    wr(0, 8'h08, 16'h0001);
    idle(8);
    rdLit(0, 8'h00, 16'h0000, "R4 halted at compare 0");
    rdLit(0, 8'h08, 16'h0001, "R4 control unchanged");
    rdLit(1, 8'h00, 16'h003F, "R7 pending on hit");
    // ack while still matching: set wins (R7)
    wr(1, 8'h00, 16'h003F);
    rdLit(1, 8'h00, 16'h003F, "R7 set beats ack");
    wr(0, 8'h08, 16'h0011);
    wr(1, 8'h00, 16'h0001);
    rdLit(1, 8'h00, 16'h003E, "R8 one clears, zero keeps");
    wr(1, 8'h00, 16'h003E);
    rdLit(1, 8'h00, 16'h0000, "R8 all cleared");
    // stopped counter holds (R3)
    wr(0, 8'h00, 16'h0040);
    idle(5);
    rdLit(0, 8'h00, 16'h0040, "R3 stopped holds");
    // divider 2: one step per 3 clocks, up, free run (R5)
    wr(0, 8'h04, 16'd2);
    wr(0, 8'h08, 16'h000F);
    idle(9);
    rdChk(0, 8'h00, "R5 divider pacing");
    wr(0, 8'h08, 16'h0018);
    // wrap through 0xFFFF, counter 1 up, halt at zero (R6, R4)
    wr(0, 8'h0C, 16'hFFFD);
    wr(0, 8'h14, 16'h0008);
    idle(6);
    rdLit(0, 8'h0C, 16'h0000, "R6 wrap then halt at zero");
    wr(0, 8'h14, 16'h0010);
    wr(1, 8'h00, 16'h003F);
    // partial mask (R9)
    wr(1, 8'h04, 16'h0002);
    wr(0, 8'h1C, 16'h0010);
    wr(0, 8'h04, 16'd0);
    wr(0, 8'h00, 16'h000C);
    wr(0, 8'h08, 16'h000A);
    idle(8);
    rdLit(0, 8'h00, 16'h0010, "R4 halted at compare 1");
    @(negedge clk); #1 check(irq == 1'b1, "R9 irq with mask bit", {15'd0, irq}, 1);
    wr(1, 8'h04, 16'h0000);
    @(negedge clk); #1 check(irq == 1'b0, "R9 irq masked off", {15'd0, irq}, 0);
    // random mix against the model (R2..R10)
    for (int i = 0; i < 600; i++) begin
      int op, sel, a;
      logic [15:0] d;
      op = int'($urandom_range(0, 9));
      sel = int'($urandom_range(0, 11));
      a = sel * 4;
      d = 16'($urandom);
      if (sel == 1 || sel == 4) d = 16'($urandom_range(0, 3));
      if (sel == 2 || sel == 5) d = 16'($urandom_range(0, 31));
      if (sel >= 6) d = 16'($urandom_range(0, 40));
      if (op < 4) wr(0, a, d);
      else if (op == 4) wr(1, 0, 16'($urandom_range(0, 63)));
      else if (op == 5) wr(1, 4, 16'($urandom_range(0, 63)));
      else if (op < 8) rdChk(0, a, "R2 random read timer window");
      else if (op == 8) rdChk(1, 0, "R7 random read pending");
      else idle(int'($urandom_range(1, 6)));
    end
    for (int s = 0; s < 12; s++) rdChk(0, s * 4, "R10 final register sweep");
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end
endmodule